// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit timer channel for use behind a register decoder. A power-of-two prescaler divides the system clock and produces count ticks. On each tick the counter moves one step up or down. It runs in one of two modes. In overflow mode it wraps across the full 16-bit range. In interval mode it wraps at a programmed top value. A wrap raises a status flag, and so does the count landing on any of three match values. Status flags are sticky. They are combined with an enable mask into one level-sensitive interrupt line.

The surrounding decoder writes two configuration words through write strobes. One is the clock word: an enable bit plus a 4-bit exponent. The other is the control word. The interval value, the match values and the interrupt mask are driven as plain levels. A single clear strobe wipes all status flags.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, all status bits are 0, irq is 0 and `ctrl_q` reads 0x21, so the channel is stopped.
- R2: The control word is `ctrl_wdata` = {bit5 spare, bit4 count-reset, bit3 match-enable, bit2 down, bit1 interval-mode, bit0 stop}. Writing it with bit 4 set zeroes the count at that write edge. Bit 4 is never stored, so `ctrl_q[4]` always reads 0.
- R3: While the stored stop bit is 1, the count holds its value on every clock.
- R4: The clock word is {bits 4:1 exponent N, bit 0 enable}. With enable set, the count advances once every 2^(N+1) clocks, counted from the write of the clock word. With enable clear, it advances on every clock whatever N holds.
- R5: In overflow mode, counting up passes 0xFFFF then 0. That wrap sets status bit 4 and leaves bit 0 clear.
- R6: In interval mode, counting up cycles through 0 to `interval` inclusive. Each step from the top value back to 0 sets status bit 0.
- R7: Counting down, a step from 0 loads the top value: `interval` in interval mode, 0xFFFF in overflow mode. It sets the same flag the upward wrap would set.
- R8: With match-enable set, a step that lands on `match[k-1]` sets status bit k (k = 1..3). A match value above the current top never fires. With match-enable clear, no match bit is set.
- R9: Status bits stay set until `sts_clr`, which zeroes them all at one edge. A flag raised at that same edge survives the clear.
- R10: `irq` is high exactly when `status & irq_en` is nonzero. Status bit 5 is never set by this channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_cfg_wr | input | 1 | Write strobe for the clock word |
| clk_cfg_wdata | input | 5 | Clock word: enable in bit 0, exponent in bits 4:1 |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 6 | Control word (see R2) |
| interval | input | 16 | Top value used in interval mode |
| match | input | 3x16 | Match values, entry k-1 drives status bit k |
| irq_en | input | 6 | Interrupt enable mask, one bit per status bit |
| sts_clr | input | 1 | Clears all status bits |
| count | output | 16 | Current counter value |
| status | output | 6 | Sticky status flags |
| irq | output | 1 | Level interrupt |
| ctrl_q | output | 6 | Stored control word |

## Verification
The bench sweeps the prescaler exponent and checks the count after every clock. An off-by-one divider shows up there as a count that runs one tick early or late. It walks full periods of the interval top in both directions. A design that wraps one count late or early, or reloads 0 instead of the top value when counting down, fails the per-step count checks. The bench runs a complete 65536-step pass in overflow mode to catch a flag raised in the wrong bit. It also places one match value above the interval top, fires a wrap and a clear at the same edge, and masks the interrupt bit by bit. A clear that beats a new flag, or a match that fires beyond the wrap limit, is reported there.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int CTRL_W   = 6;
   localparam int CB_STOP  = 0;
   localparam int CB_IVL   = 1;
   localparam int CB_DOWN  = 2;
   localparam int CB_MATCH = 3;
   localparam int CB_ZERO  = 4;
   localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 6'h21;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             en,
   input  logic [PSC_W-1:0] expo,
   output logic             tick
);
   localparam int PCNT_W = 1 << PSC_W;

   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] lim;

   // terminal count is 2^(expo+1)-1
   always_comb begin
      lim  = {PCNT_W{1'b1}} >> (PCNT_W - 1 - int'(expo));
      tick = !en || (pcnt == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (restart)
         pcnt <= '0;
      else if (en)
         pcnt <= tick ? '0 : pcnt + 1'b1;
   end

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !restart) |=> !tick);
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             zero,
   input  logic             down,
   input  logic             use_lim,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] nxt,
   output logic [CNT_W-1:0] top,
   output logic             wrap
);
   always_comb begin
      top = use_lim ? limit : {CNT_W{1'b1}};
      if (down) begin
         wrap = (cnt_q == '0);
         nxt  = wrap ? top : cnt_q - 1'b1;
      end else begin
         wrap = (cnt_q >= top);
         nxt  = wrap ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (zero)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= nxt;
   end

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !zero) |=> $stable(cnt_q));
   // R6
   up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !zero && !down && wrap) |=> (cnt_q == '0));
   // R7
   down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !zero && down && wrap) |=> (cnt_q == $past(top)));
endmodule

// File: rtl/pit_status.sv
module pit_status #(
   parameter int CNT_W     = 16,
   parameter int NUM_MATCH = 3,
   localparam int STS_W    = NUM_MATCH + 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            adv,
   input  logic                            wrap,
   input  logic                            use_lim,
   input  logic                            match_en,
   input  logic [CNT_W-1:0]                nxt,
   input  logic [CNT_W-1:0]                top,
   input  logic [NUM_MATCH-1:0][CNT_W-1:0] match,
   input  logic                            clr,
   output logic [STS_W-1:0]                sts_q
);
   localparam int OVF_BIT = NUM_MATCH + 1;
   localparam int EVT_BIT = NUM_MATCH + 2;

   logic [STS_W-1:0] set;

   assign set[0]       = adv && wrap && use_lim;
   assign set[OVF_BIT] = adv && wrap && !use_lim;
   assign set[EVT_BIT] = 1'b0;

   for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
      assign set[k+1] = adv && match_en && (nxt == match[k]) && (match[k] <= top);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sts_q <= '0;
      else
         sts_q <= (clr ? '0 : sts_q) | set;
   end

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
   // R10
   evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_q[EVT_BIT]);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PSC_W     = 4,
   parameter int NUM_MATCH = 3,
   localparam int STS_W    = NUM_MATCH + 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clk_cfg_wr,
   input  logic [PSC_W:0]                  clk_cfg_wdata,
   input  logic                            ctrl_wr,
   input  logic [CTRL_W-1:0]               ctrl_wdata,
   input  logic [CNT_W-1:0]                interval,
   input  logic [NUM_MATCH-1:0][CNT_W-1:0] match,
   input  logic [STS_W-1:0]                irq_en,
   input  logic                            sts_clr,
   output logic [CNT_W-1:0]                count,
   output logic [STS_W-1:0]                status,
   output logic                            irq,
   output logic [CTRL_W-1:0]               ctrl_q
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (PSC_W < 1 || PSC_W > 5) begin : g_bad_psc
      $error("PSC_W must be 1..5");
   end

   logic [PSC_W:0]   clk_cfg_q;
   logic             tick, adv, zero;
   logic [CNT_W-1:0] nxt, top;
   logic             wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_cfg_q <= '0;
         ctrl_q    <= CTRL_RST_VAL;
      end else begin
         if (clk_cfg_wr)
            clk_cfg_q <= clk_cfg_wdata;
         if (ctrl_wr)
            ctrl_q <= ctrl_wdata & ~(CTRL_W'(1) << CB_ZERO);
      end
   end

   assign zero = ctrl_wr && ctrl_wdata[CB_ZERO];
   assign adv  = tick && !ctrl_q[CB_STOP] && !zero;

   pit_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (clk_cfg_wr || ctrl_q[CB_STOP]),
      .en      (clk_cfg_q[0]),
      .expo    (clk_cfg_q[PSC_W:1]),
      .tick    (tick)
   );

   pit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .zero    (zero),
      .down    (ctrl_q[CB_DOWN]),
      .use_lim (ctrl_q[CB_IVL]),
      .limit   (interval),
      .cnt_q   (count),
      .nxt     (nxt),
      .top     (top),
      .wrap    (wrap)
   );

   pit_status #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .wrap     (wrap),
      .use_lim  (ctrl_q[CB_IVL]),
      .match_en (ctrl_q[CB_MATCH]),
      .nxt      (nxt),
      .top      (top),
      .match    (match),
      .clr      (sts_clr),
      .sts_q    (status)
   );

   assign irq = |(status & irq_en);

   // R2
   ctrl_zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_ZERO]);
   // R2
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> (count == '0));
endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
   localparam int CLK_PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clk_cfg_wr = 1'b0;
   logic [4:0]       clk_cfg_wdata = '0;
   logic             ctrl_wr = 1'b0;
   logic [5:0]       ctrl_wdata = '0;
   logic [15:0]      interval = '0;
   logic [2:0][15:0] match = '0;
   logic [5:0]       irq_en = '0;
   logic             sts_clr = 1'b0;
   logic [15:0]      count;
   logic [5:0]       status;
   logic             irq;
   logic [5:0]       ctrl_q;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pit_channel u0 (
      .clk(clk), .rst_n(rst_n),
      .clk_cfg_wr(clk_cfg_wr), .clk_cfg_wdata(clk_cfg_wdata),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .interval(interval), .match(match), .irq_en(irq_en),
      .sts_clr(sts_clr), .count(count), .status(status),
      .irq(irq), .ctrl_q(ctrl_q)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [5:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wr_both(input logic [4:0] c, input logic [5:0] v);
      clk_cfg_wr = 1'b1; clk_cfg_wdata = c;
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      clk_cfg_wr = 1'b0; ctrl_wr = 1'b0;
   endtask

   task automatic clear_sts();
      sts_clr = 1'b1;
      @(negedge clk);
      sts_clr = 1'b0;
   endtask

   // stop, clear flags, then start in the given mode from count 0
   task automatic restart(input logic [5:0] mode);
      wr_ctrl(6'h11);
      clear_sts();
      wr_ctrl(mode | 6'h10);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      check("R1 count", int'(count), 0);
      check("R1 status", int'(status), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 ctrl", int'(ctrl_q), 'h21);
      // R3 stopped after reset
      step(5);
      check("R3 hold", int'(count), 0);

      // R2 reset bit not stored, zeroes count
      wr_ctrl(6'h10);
      check("R2 readback", int'(ctrl_q), 0);
      step(3);
      check("R2 run", int'(count), 3);
      wr_ctrl(6'h10);
      check("R2 zero", int'(count), 0);

      // R4 prescaler sweep
      for (int n = 0; n < 4; n++) begin
         wr_both({4'(n), 1'b1}, 6'h10);
         for (int k = 1; k <= 24; k++) begin
            step(1);
            check("R4 prescaled", int'(count), k / (1 << (n + 1)));
         end
      end
      wr_both({4'd3, 1'b0}, 6'h10);
      for (int k = 1; k <= 8; k++) begin
         step(1);
         check("R4 bypass", int'(count), k);
      end

      // R5 overflow mode, up
      restart(6'h00);
      step(65535);
      check("R5 top", int'(count), 'hFFFF);
      check("R5 no flag yet", int'(status), 0);
      step(1);
      check("R5 wrap count", int'(count), 0);
      check("R5 ovf flag", int'(status), 'h10);

      // R6 interval mode, up
      interval = 16'd9;
      restart(6'h02);
      for (int k = 1; k <= 25; k++) begin
         step(1);
         check("R6 count", int'(count), k % 10);
         if (k == 9)  check("R6 before wrap", int'(status), 0);
         if (k == 10) check("R6 ivl flag", int'(status), 'h01);
      end

      // R7 down, interval mode
      restart(6'h06);
      for (int k = 1; k <= 25; k++) begin
         step(1);
         check("R7 down count", int'(count), (10 - (k % 10)) % 10);
         if (k == 1) check("R7 ivl flag", int'(status), 'h01);
      end
      // R7 down, overflow mode
      restart(6'h04);
      step(1);
      check("R7 reload", int'(count), 'hFFFF);
      check("R7 ovf flag", int'(status), 'h10);

      // R8 match flags
      match[0] = 16'd3; match[1] = 16'd7; match[2] = 16'd20;
      restart(6'h0A);
      step(3);
      check("R8 match1", int'(status), 'h02);
      step(4);
      check("R8 match2", int'(status), 'h06);
      step(23);
      check("R8 match3 above top", int'(status), 'h07);
      restart(6'h02);
      step(30);
      check("R8 match disabled", int'(status), 'h01);

      // R9 sticky, clear, and set beating clear
      step(5);
      check("R9 sticky", int'(status), 'h01);
      clear_sts();
      check("R9 cleared", int'(status), 0);
      restart(6'h02);
      step(9);
      check("R9 pre", int'(status), 0);
      clear_sts();
      check("R9 set wins", int'(status), 'h01);

      // R10 interrupt masking
      irq_en = 6'h3E; #1;
      check("R10 masked", int'(irq), 0);
      irq_en = 6'h01; #1;
      check("R10 enabled", int'(irq), 1);
      irq_en = 6'h3F;
      clear_sts();
      check("R10 after clear", int'(irq), 0);

      // R3 stop holds count
      wr_ctrl(6'h03);
      begin
         int held;
         held = int'(count);
         step(10);
         check("R3 stopped", int'(count), held);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule